// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block turns single bus-phase commands from a byte engine into correctly timed open-drain SCL and SDA drive for an I2C master. The engine asks for one of three phases: a START, which is repeated automatically when SCL is currently held low; one data bit, either sent or received; or a STOP. The block then walks through the timed segments of that phase and pulses `phase_done` once the phase is over. The bench-side or pad-side logic turns the two `*_oe` outputs into pull-down drivers. A high `*_oe` means the line is pulled low.

All durations are programmed through byte-wide fields. A prescaler emits one tick every `t_div+1` clocks, and every segment lasts a whole number of ticks. Each SCL level of a data bit is followed by an extra `4+t_flt` clocks, which account for the input glitch filter. One data bit therefore lasts (t_div+1)*(t_scl_lo+t_scl_hi+2) + 8 + 2*t_flt clocks. SDA from the bus passes through a two-flop synchronizer. It is sampled halfway through the high tick count, both to capture read and ACK bits and to detect a lost arbitration.

Top module: `i2c_tg_top`

## Requirements
- R1: While in reset and afterwards until the first command, `scl_oe`=0, `sda_oe`=0, `cmd_ready`=1, `phase_done`=0 and `arb_lost`=0.
- R2: A bit command (`cmd_op`=1) keeps `cmd_ready` low for exactly (t_div+1)*(t_scl_lo+t_scl_hi+2)+8+2*t_flt clocks, provided t_dat_hd+t_dat_su <= t_scl_lo.
- R3: During a bit, SCL is released (`scl_oe`=0) for exactly (t_div+1)*(t_scl_hi+1)+4+t_flt clocks. Otherwise it is held low.
- R4: If t_dat_hd+t_dat_su > t_scl_lo, the low part of a bit grows to (t_div+1)*(t_dat_hd+t_dat_su+1)+4+t_flt clocks. The high part is unchanged.
- R5: The new SDA level of a bit appears (t_div+1)*t_dat_hd+1 clocks after the bit starts, while SCL is low. SDA does not change while SCL is released during a bit. A sent 0 pulls SDA low. A sent 1 or a received bit (`cmd_rx`=1) releases it.
- R6: A START (`cmd_op`=0) from a released SCL lasts (t_div+1)*(t_sta_su+t_sta_hd+2) clocks. SDA is pulled low while SCL is released, and the START ends with both lines pulled low.
- R7: A START issued while SCL is held low first releases SDA with SCL low for t_rs_rel+1 ticks. It then performs the START of R6, for a total of (t_div+1)*(t_rs_rel+t_sta_su+t_sta_hd+3) clocks.
- R8: A STOP (`cmd_op`=2) holds SCL low with SDA pulled low for max(t_scl_lo+1, t_dat_hd+t_dat_su+1) ticks. It then releases SCL for t_sto_su+1 ticks and ends with both lines released.
- R9: After a bit, `rx_bit` holds the synchronized SDA level sampled in the high segment at tick t_scl_hi/2 (integer division).
- R10: `arb_lost` sets when a sent 1 samples SDA low, and only while SCL is released. It stays set through later bits and STOPs until the next START is accepted. A received bit never sets it.
- R11: `phase_done` is a one-clock pulse, raised in the first ready clock after each phase. A command with `cmd_op`=3 is ignored: `cmd_ready` stays 1, no pulse appears and the lines do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 0 START, 1 bit, 2 STOP, 3 ignored |
| cmd_bit | input | 1 | Bit value to send |
| cmd_rx | input | 1 | 1: receive this bit (SDA released, no arbitration check) |
| cmd_ready | output | 1 | Idle, ready for a command |
| t_div | input | TW | Prescaler: one tick per t_div+1 clocks |
| t_scl_lo | input | TW | SCL low ticks minus one |
| t_scl_hi | input | TW | SCL high ticks minus one |
| t_sta_su | input | TW | START setup ticks minus one |
| t_sta_hd | input | TW | START hold ticks minus one |
| t_sto_su | input | TW | STOP setup ticks minus one |
| t_dat_su | input | TW | Data setup ticks before SCL release |
| t_dat_hd | input | TW | Data hold ticks after SCL falls |
| t_rs_rel | input | TW | Repeated-start release ticks minus one |
| t_flt | input | FW | Filter cycles added to each SCL level |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| phase_done | output | 1 | One-clock end-of-phase pulse |
| rx_bit | output | 1 | Last sampled SDA bit |
| arb_lost | output | 1 | Sticky arbitration-lost flag |

## Verification
The hardest conditions to reach are a lost arbitration and the stretched low phase. Both depend on a second party or on an awkward combination of fields rather than on one command. The bench models a slave that can hold SDA low during chosen bits. It runs each configuration of a small sweep through the same phase sequence: START, sent 1, received bit with the slave pulling low, sent 1 against that pull, sent 0, repeated START, then STOP. Half of the sweep sets data hold plus setup one tick beyond the low count, which forces the stretch.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BIT   = 2'd1,
    OP_STOP  = 2'd2,
    OP_NONE  = 2'd3
  } tg_op_e;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_RS_REL = 4'd1,
    S_ST_SU  = 4'd2,
    S_ST_HD  = 4'd3,
    S_B_LO   = 4'd4,
    S_B_LO_X = 4'd5,
    S_B_HI   = 4'd6,
    S_B_HI_X = 4'd7,
    S_SP_LO  = 4'd8,
    S_SP_SU  = 4'd9
  } tg_state_e;

endpackage

// File: rtl/i2c_tg_prescale.sv
module i2c_tg_prescale #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] div,
  output logic          tick
);

  logic [TW-1:0] pc_q;
  logic [TW-1:0] pc_d;

  always_comb begin
    tick = (pc_q == div);
    if (restart || tick) pc_d = '0;
    else                 pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/i2c_tg_tickcnt.sv
module i2c_tg_tickcnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/i2c_tg_sync.sv
module i2c_tg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b1;
          else        sh_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b1;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/i2c_tg_top.sv
module i2c_tg_top
  import i2c_tg_pkg::*;
#(
  parameter int TW = 8,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  input  logic          cmd_rx,
  output logic          cmd_ready,
  input  logic [TW-1:0] t_div,
  input  logic [TW-1:0] t_scl_lo,
  input  logic [TW-1:0] t_scl_hi,
  input  logic [TW-1:0] t_sta_su,
  input  logic [TW-1:0] t_sta_hd,
  input  logic [TW-1:0] t_sto_su,
  input  logic [TW-1:0] t_dat_su,
  input  logic [TW-1:0] t_dat_hd,
  input  logic [TW-1:0] t_rs_rel,
  input  logic [FW-1:0] t_flt,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          phase_done,
  output logic          rx_bit,
  output logic          arb_lost
);

  localparam int CW  = TW + 2;
  localparam int OCW = FW + 2;
  localparam logic [OCW-1:0] OVH_BASE = OCW'(4);

  tg_state_e      st_q, st_d;
  logic           scl_q, scl_d;
  logic           sda_q, sda_d;
  logic           done_q, done_d;
  logic           rx_q, rx_d;
  logic           arb_q, arb_d;
  logic           bit_q, bit_d;
  logic           rxm_q, rxm_d;
  logic [OCW-1:0] oc_q, oc_d;

  logic           restart;
  logic           tick;
  logic [CW-1:0]  tc;
  logic           sda_sync;

  logic [CW-1:0]  lo_base, lo_need, lo_tgt, target;
  logic [OCW-1:0] ovh_len;
  logic           seg_end, ovh_end;
  logic           at_hold, at_mid;

  i2c_tg_prescale #(.TW(TW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div     (t_div),
    .tick    (tick)
  );

  i2c_tg_tickcnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .cnt     (tc)
  );

  i2c_tg_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_in),
    .q     (sda_sync)
  );

  // Segment lengths in ticks
  always_comb begin
    lo_base = CW'(t_scl_lo) + 1'b1;
    lo_need = CW'(t_dat_hd) + CW'(t_dat_su) + 1'b1;
    lo_tgt  = (lo_need > lo_base) ? lo_need : lo_base;
    ovh_len = OVH_BASE + OCW'(t_flt);
    unique case (st_q)
      S_RS_REL: target = CW'(t_rs_rel) + 1'b1;
      S_ST_SU:  target = CW'(t_sta_su) + 1'b1;
      S_ST_HD:  target = CW'(t_sta_hd) + 1'b1;
      S_B_LO:   target = lo_tgt;
      S_B_HI:   target = CW'(t_scl_hi) + 1'b1;
      S_SP_LO:  target = lo_tgt;
      S_SP_SU:  target = CW'(t_sto_su) + 1'b1;
      default:  target = '1;
    endcase
    seg_end = tick && ((tc + 1'b1) == target);
    ovh_end = (oc_q == (ovh_len - 1'b1));
    at_hold = (tc == CW'(t_dat_hd));
    at_mid  = tick && (tc == CW'(t_scl_hi >> 1));
  end

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    done_d  = 1'b0;
    rx_d    = rx_q;
    arb_d   = arb_q;
    bit_d   = bit_q;
    rxm_d   = rxm_q;
    restart = 1'b0;
    if (st_q == S_B_LO_X || st_q == S_B_HI_X) oc_d = oc_q + 1'b1;
    else                                      oc_d = '0;

    unique case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          unique case (tg_op_e'(cmd_op))
            OP_START: begin
              arb_d   = 1'b0;
              restart = 1'b1;
              st_d    = scl_q ? S_RS_REL : S_ST_SU;
            end
            OP_BIT: begin
              bit_d   = cmd_bit;
              rxm_d   = cmd_rx;
              restart = 1'b1;
              st_d    = S_B_LO;
            end
            OP_STOP: begin
              restart = 1'b1;
              st_d    = S_SP_LO;
            end
            default: ;
          endcase
        end
      end
      S_RS_REL: begin
        if (at_hold) sda_d = 1'b0;
        if (seg_end) begin
          st_d = S_ST_SU; scl_d = 1'b0; sda_d = 1'b0; restart = 1'b1;
        end
      end
      S_ST_SU: begin
        if (seg_end) begin
          st_d = S_ST_HD; sda_d = 1'b1; restart = 1'b1;
        end
      end
      S_ST_HD: begin
        if (seg_end) begin
          st_d = S_IDLE; scl_d = 1'b1; done_d = 1'b1; restart = 1'b1;
        end
      end
      S_B_LO: begin
        if (at_hold) sda_d = rxm_q ? 1'b0 : !bit_q;
        if (seg_end) begin
          st_d = S_B_LO_X; restart = 1'b1;
        end
      end
      S_B_LO_X: begin
        if (ovh_end) begin
          st_d = S_B_HI; scl_d = 1'b0; restart = 1'b1; oc_d = '0;
        end
      end
      S_B_HI: begin
        if (at_mid) begin
          rx_d = sda_sync;
          if (!rxm_q && bit_q && !sda_sync) arb_d = 1'b1;
        end
        if (seg_end) begin
          st_d = S_B_HI_X; restart = 1'b1;
        end
      end
      S_B_HI_X: begin
        if (ovh_end) begin
          st_d = S_IDLE; scl_d = 1'b1; done_d = 1'b1; restart = 1'b1; oc_d = '0;
        end
      end
      S_SP_LO: begin
        if (at_hold) sda_d = 1'b1;
        if (seg_end) begin
          st_d = S_SP_SU; scl_d = 1'b0; sda_d = 1'b1; restart = 1'b1;
        end
      end
      S_SP_SU: begin
        if (seg_end) begin
          st_d = S_IDLE; sda_d = 1'b0; done_d = 1'b1; restart = 1'b1;
        end
      end
      default: begin
        st_d = S_IDLE; restart = 1'b1;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= 1'b1;
      arb_q  <= 1'b0;
      bit_q  <= 1'b1;
      rxm_q  <= 1'b0;
      oc_q   <= '0;
    end else begin
      st_q   <= st_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
      rx_q   <= rx_d;
      arb_q  <= arb_d;
      bit_q  <= bit_d;
      rxm_q  <= rxm_d;
      oc_q   <= oc_d;
    end
  end

  assign cmd_ready  = (st_q == S_IDLE);
  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign phase_done = done_q;
  assign rx_bit     = rx_q;
  assign arb_lost   = arb_q;

endmodule

// File: rtl/i2c_tg_chk.sv
module i2c_tg_chk
  import i2c_tg_pkg::*;
#(
  parameter int TW = 8,
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          cmd_ready,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          phase_done,
  input logic          arb_lost,
  input tg_state_e     st,
  input logic [TW-1:0] t_div,
  input logic [TW-1:0] t_scl_lo,
  input logic [TW-1:0] t_scl_hi,
  input logic [TW-1:0] t_dat_su,
  input logic [TW-1:0] t_dat_hd,
  input logic [FW-1:0] t_flt
);

  logic [31:0] busy_q;
  logic        was_bit_q;
  logic [31:0] bit_exp;
  logic        no_stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= '0;
      was_bit_q <= 1'b0;
    end else if (cmd_valid && cmd_ready && cmd_op != 2'd3) begin
      busy_q    <= '0;
      was_bit_q <= (cmd_op == 2'd1);
    end else if (!cmd_ready) begin
      busy_q    <= busy_q + 1;
    end
  end

  always_comb begin
    bit_exp = (32'(t_div) + 1) * (32'(t_scl_lo) + 32'(t_scl_hi) + 2) + 8 + 2 * 32'(t_flt);
    no_stretch = (32'(t_dat_hd) + 32'(t_dat_su)) <= 32'(t_scl_lo);
  end

  // R2: busy length of a bit
  a_r2_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && was_bit_q && no_stretch) |-> (busy_q == bit_exp));

  // R5: SDA steady while SCL released inside a bit
  a_r5_sda_still_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_B_HI || st == S_B_HI_X) && ($past(st) == S_B_HI || $past(st) == S_B_HI_X))
      |-> $stable(sda_oe));

  // R6: SDA falls with SCL released only as START hold begins
  a_r6_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> (st == S_ST_HD));

  // R8: SDA rises with SCL released only at the end of a STOP
  a_r8_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> (st == S_IDLE && phase_done));

  // R10: arbitration loss only detected while SCL released
  a_r10_arb_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !scl_oe);

  // R11: completion is a single pulse in the ready state
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |=> !phase_done);

  a_r11_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> cmd_ready);

endmodule

bind i2c_tg_top i2c_tg_chk #(.TW(TW), .FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_ready  (cmd_ready),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .phase_done (phase_done),
  .arb_lost   (arb_lost),
  .st         (st_q),
  .t_div      (t_div),
  .t_scl_lo   (t_scl_lo),
  .t_scl_hi   (t_scl_hi),
  .t_dat_su   (t_dat_su),
  .t_dat_hd   (t_dat_hd),
  .t_flt      (t_flt)
);

// File: tb/i2c_tg_top_test.sv
module i2c_tg_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int FW = 3;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic          cmd_bit;
  logic          cmd_rx;
  logic          cmd_ready;
  logic [TW-1:0] t_div, t_scl_lo, t_scl_hi, t_sta_su, t_sta_hd;
  logic [TW-1:0] t_sto_su, t_dat_su, t_dat_hd, t_rs_rel;
  logic [FW-1:0] t_flt;
  logic          sda_in;
  logic          scl_oe, sda_oe, phase_done, rx_bit, arb_lost;
  logic          slave_low;

  int n_cmp = 0;
  int n_bad = 0;
  int busy_n, hi_n, chg_n, done_n;

  assign sda_in = !sda_oe && !slave_low;

  i2c_tg_top #(.TW(TW), .FW(FW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_rx(cmd_rx),
    .cmd_ready(cmd_ready),
    .t_div(t_div), .t_scl_lo(t_scl_lo), .t_scl_hi(t_scl_hi),
    .t_sta_su(t_sta_su), .t_sta_hd(t_sta_hd), .t_sto_su(t_sto_su),
    .t_dat_su(t_dat_su), .t_dat_hd(t_dat_hd), .t_rs_rel(t_rs_rel), .t_flt(t_flt),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .phase_done(phase_done), .rx_bit(rx_bit), .arb_lost(arb_lost)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = !clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic b, input logic rx);
    logic prev;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    prev = sda_oe;
    cmd_op = op; cmd_bit = b; cmd_rx = rx; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_n = 0; hi_n = 0; chg_n = -1;
    while (!cmd_ready) begin
      busy_n++;
      if (!scl_oe) hi_n++;
      if (sda_oe != prev && chg_n < 0) chg_n = busy_n;
      prev = sda_oe;
      @(negedge clk);
    end
    done_n = int'(phase_done);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_bit = 1'b0; cmd_rx = 1'b0;
    slave_low = 1'b0;
    t_div = 8'd0; t_scl_lo = 8'd2; t_scl_hi = 8'd1; t_sta_su = 8'd2; t_sta_hd = 8'd1;
    t_sto_su = 8'd2; t_dat_su = 8'd1; t_dat_hd = 8'd0; t_rs_rel = 8'd1; t_flt = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 done", int'(phase_done), 0);
    chk("R1 arb", int'(arb_lost), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready after release", int'(cmd_ready), 1);

    // R11 reserved op is ignored
    cmd_op = 2'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R11 ignored ready", int'(cmd_ready), 1);
      chk("R11 ignored done", int'(phase_done), 0);
      chk("R11 ignored lines", int'({scl_oe, sda_oe}), 0);
      @(negedge clk);
    end

    for (int d = 0; d < 3; d++)
    for (int lo = 2; lo < 4; lo++)
    for (int hi = 1; hi < 3; hi++)
    for (int fi = 0; fi < 2; fi++)
    for (int dh = 0; dh < 2; dh++)
    for (int ex = 0; ex < 2; ex++) begin
      int flt, dsu, lot, per, hit, su, hd, sto, rs;
      flt = fi * 5; dsu = lo - dh + ex;
      su = lo; hd = 1; sto = 2; rs = 1;
      lot = (dh + dsu + 1 > lo + 1) ? dh + dsu + 1 : lo + 1;
      per = (d + 1) * (lot + hi + 1) + 8 + 2 * flt;
      hit = (d + 1) * (hi + 1) + 4 + flt;
      @(negedge clk);
      t_div = TW'(d); t_scl_lo = TW'(lo); t_scl_hi = TW'(hi); t_flt = FW'(flt);
      t_dat_hd = TW'(dh); t_dat_su = TW'(dsu); t_sta_su = TW'(su);
      t_sta_hd = TW'(hd); t_sto_su = TW'(sto); t_rs_rel = TW'(rs);
      slave_low = 1'b0;

      // R6 START from idle bus
      issue(2'd0, 1'b0, 1'b0);
      chk("R6 start length", busy_n, (d + 1) * (su + hd + 2));
      chk("R6 start end lines", int'({scl_oe, sda_oe}), 3);
      chk("R11 start done", done_n, 1);
      chk("R10 cleared by start", int'(arb_lost), 0);

      // sent 1, bus free
      issue(2'd1, 1'b1, 1'b0);
      if (ex == 0) chk("R2 bit length", busy_n, per);
      else         chk("R4 stretched bit length", busy_n, per);
      chk("R3 high time", hi_n, hit);
      chk("R5 sda release point", chg_n, (d + 1) * dh + 2);
      chk("R9 rx sent 1", int'(rx_bit), 1);
      chk("R10 no arb", int'(arb_lost), 0);
      chk("R11 bit done", done_n, 1);

      // received bit, slave pulls low
      slave_low = 1'b1;
      issue(2'd1, 1'b1, 1'b1);
      chk("R9 rx reads 0", int'(rx_bit), 0);
      chk("R10 rx no arb", int'(arb_lost), 0);
      chk("R5 rx releases", int'(sda_oe), 0);

      // sent 1 against slave pull
      issue(2'd1, 1'b1, 1'b0);
      chk("R10 arb set", int'(arb_lost), 1);
      slave_low = 1'b0;

      // sent 0
      issue(2'd1, 1'b0, 1'b0);
      chk("R5 sda pull point", chg_n, (d + 1) * dh + 2);
      chk("R5 sent 0 pulls", int'(sda_oe), 1);
      chk("R10 arb sticky", int'(arb_lost), 1);

      // R7 repeated START
      issue(2'd0, 1'b0, 1'b0);
      chk("R7 restart length", busy_n, (d + 1) * (rs + su + hd + 3));
      chk("R7 restart end", int'({scl_oe, sda_oe}), 3);
      chk("R10 cleared by restart", int'(arb_lost), 0);

      // R8 STOP
      issue(2'd2, 1'b0, 1'b0);
      chk("R8 stop length", busy_n, (d + 1) * (lot + sto + 1));
      chk("R8 stop high time", hi_n, (d + 1) * (sto + 1));
      chk("R8 stop end lines", int'({scl_oe, sda_oe}), 0);
      chk("R11 stop done", done_n, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule